// File: doc/BRIEF.md
# Receive Missed-Frame Error Counter

This block keeps a 16-bit tally of received Ethernet frames that the receive MAC lost or found damaged. The receive datapath raises a one-cycle end-of-frame strobe together with per-frame error flags. The block adds one to its tally for each strobe that carries at least one counting error: an alignment (dribbling-bit) fault, a bad CRC, a receive FIFO overflow, or a discard because reception was switched off. Frames that the destination-address filter rejected are never counted.

Software reaches the block through a small word-wide register port with three locations. The tally register returns the live count on a read and is cleared by that same read. A write loads a new starting point, so software can choose how soon the 16-bit field overflows. Software is expected to accumulate the wider total itself. When the tally wraps from its top value to zero, a sticky overflow flag is set. A level interrupt follows that flag whenever its enable is on.

Top module: `rx_miss_counter`

## Requirements
- R1: After reset the tally is 0x7FFF, the overflow flag and its enable are 0, and `irq` is low.
- R2: While `reg_rd` is high with `reg_addr`=0, `reg_rdata` holds the tally in bits 15:0 and zeros in bits 31:16. On the following clock edge the tally becomes 0.
- R3: A write with `reg_addr`=0 loads `reg_wdata[15:0]` into the tally, and later increments count up from that value.
- R4: An end-of-frame strobe with `err_align` or `err_crc` set, and `addr_reject` clear, adds exactly one to the tally at that clock edge.
- R5: An end-of-frame strobe with `err_fifo_ovf` or `err_rx_off` set, and `addr_reject` clear, adds exactly one to the tally.
- R6: The tally does not change for a strobe that has `addr_reject` set, for a strobe with no error flag, or for error flags that arrive without a strobe.
- R7: A strobe carrying several error flags at once adds exactly one to the tally.
- R8: An increment from 0xFFFF wraps the tally to 0x0000 and sets the overflow flag, which reads as bit 0 at `reg_addr`=1.
- R9: When a tally read or tally write falls in the same cycle as a counting strobe, the software access takes effect and the increment is lost. A strobe at 0xFFFF in that cycle does not set the overflow flag.
- R10: Writing 1 to bit 0 at `reg_addr`=1 clears the overflow flag, and writing 0 there leaves it unchanged. A wrap in the same cycle as that write leaves the flag set.
- R11: The interrupt enable is bit 0 at `reg_addr`=2 and can be read and written there. `irq` is a registered level that is high exactly while both the overflow flag and its enable are 1, and it changes on the same edge as they do. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eof_valid | input | 1 | One-cycle end-of-frame strobe |
| err_align | input | 1 | Frame had an alignment error |
| err_crc | input | 1 | Frame had a CRC error |
| err_fifo_ovf | input | 1 | Frame was dropped on receive FIFO overflow |
| err_rx_off | input | 1 | Frame was dropped because reception was disabled |
| addr_reject | input | 1 | Frame was rejected by the address filter |
| reg_addr | input | 2 | Register select: 0 tally, 1 status, 2 enable |
| reg_rd | input | 1 | Read access strobe |
| reg_wr | input | 1 | Write access strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the access cycle |
| irq | output | 1 | Overflow interrupt level |

## Verification
The hardest case to reach from the ports is the wrap. The reset value sits 32768 increments below it, and every tally read sends the count back to zero. The stimulus therefore often preloads the tally with values in the last sixteen counts before 0xFFFF and keeps reads sparse, so that random error frames carry it across the wrap many times. Directed steps then place the wrap on the same edge as a read, a preload or a status clear, to check the priority rules.

// File: rtl/rx_miss_pkg.sv
package rx_miss_pkg;

    localparam int CNT_W   = 16;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam logic [CNT_W-1:0] CNT_RESET = 16'h7FFF;

    localparam logic [ADDR_W-1:0] ADDR_TALLY  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd2;

    typedef struct packed {
        logic align;
        logic crc;
        logic fifo_ovf;
        logic rx_off;
        logic addr_rej;
    } rx_err_t;

    typedef struct packed {
        logic              rd_tally;
        logic              wr_tally;
        logic              wr_status;
        logic              wr_enable;
        logic [REG_W-1:0]  wdata;
    } sw_req_t;

    // A frame counts when any lost/damaged cause is present and the address filter did not reject it.
    function automatic logic frame_counts(input rx_err_t f);
        return (f.align | f.crc | f.fifo_ovf | f.rx_off) & ~f.addr_rej;
    endfunction

    function automatic logic [REG_W-1:0] widen(input logic [CNT_W-1:0] v);
        return {{(REG_W-CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/rx_miss_event.sv
module rx_miss_event
    import rx_miss_pkg::*;
(
    input  logic    eof_valid,
    input  rx_err_t flags,
    output logic    inc
);
    always_comb begin
        inc = eof_valid & frame_counts(flags);
    end
endmodule

// File: rtl/rx_miss_tally.sv
module rx_miss_tally #(
    parameter int                 W       = 16,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        wrap = inc & ~clr & ~load & (count == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst)       count <= RST_VAL;
        else if (clr)  count <= '0;
        else if (load) count <= load_val;
        else if (inc)  count <= count + 1'b1;
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));
    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (count == $past(load_val)));
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !load) |=> (count == $past(count) + 1'b1));
    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr && !load) |=> $stable(count));
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0));
endmodule

// File: rtl/rx_miss_status.sv
module rx_miss_status (
    input  logic clk,
    input  logic rst,
    input  logic set_ovf,
    input  logic clr_ovf,
    input  logic en_wr,
    input  logic en_val,
    output logic sticky,
    output logic en,
    output logic irq
);
    logic sticky_n;
    logic en_n;

    always_comb begin
        sticky_n = set_ovf ? 1'b1 : (clr_ovf ? 1'b0 : sticky);
        en_n     = en_wr ? en_val : en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= 1'b0;
            en     <= 1'b0;
            irq    <= 1'b0;
        end else begin
            sticky <= sticky_n;
            en     <= en_n;
            irq    <= sticky_n & en_n;
        end
    end

    assert_sticky_set_R8: assert property (@(posedge clk) disable iff (rst)
        set_ovf |=> sticky);
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!set_ovf && !clr_ovf) |=> $stable(sticky));
    assert_irq_level_R11: assert property (@(posedge clk) disable iff (rst)
        irq == (sticky && en));
endmodule

// File: rtl/rx_miss_counter.sv
module rx_miss_counter
    import rx_miss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eof_valid,
    input  logic              err_align,
    input  logic              err_crc,
    input  logic              err_fifo_ovf,
    input  logic              err_rx_off,
    input  logic              addr_reject,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    rx_err_t          flags;
    sw_req_t          req;
    logic             inc;
    logic             wrap;
    logic             sticky;
    logic             en;
    logic [CNT_W-1:0] count;

    always_comb begin
        flags.align    = err_align;
        flags.crc      = err_crc;
        flags.fifo_ovf = err_fifo_ovf;
        flags.rx_off   = err_rx_off;
        flags.addr_rej = addr_reject;

        req.rd_tally  = reg_rd & (reg_addr == ADDR_TALLY);
        req.wr_tally  = reg_wr & (reg_addr == ADDR_TALLY);
        req.wr_status = reg_wr & (reg_addr == ADDR_STATUS);
        req.wr_enable = reg_wr & (reg_addr == ADDR_ENABLE);
        req.wdata     = reg_wdata;
    end

    rx_miss_event u_event (
        .eof_valid (eof_valid),
        .flags     (flags),
        .inc       (inc)
    );

    rx_miss_tally #(.W(CNT_W), .RST_VAL(CNT_RESET)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc),
        .clr      (req.rd_tally),
        .load     (req.wr_tally),
        .load_val (req.wdata[CNT_W-1:0]),
        .count    (count),
        .wrap     (wrap)
    );

    rx_miss_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_ovf (wrap),
        .clr_ovf (req.wr_status & req.wdata[0]),
        .en_wr   (req.wr_enable),
        .en_val  (req.wdata[0]),
        .sticky  (sticky),
        .en      (en),
        .irq     (irq)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_TALLY:  reg_rdata = widen(count);
            ADDR_STATUS: reg_rdata = {{(REG_W-1){1'b0}}, sticky};
            ADDR_ENABLE: reg_rdata = {{(REG_W-1){1'b0}}, en};
            default:     reg_rdata = '0;
        endcase
    end

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:CNT_W] == '0);
endmodule

// File: tb/test_rx_miss_counter.sv
module test_rx_miss_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eof_valid = 1'b0;
    logic        err_align = 1'b0, err_crc = 1'b0, err_fifo_ovf = 1'b0, err_rx_off = 1'b0;
    logic        addr_reject = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_cnt;
    logic        m_sticky, m_en, m_irq;

    always #2 clk = ~clk;

    rx_miss_counter i_rx_miss_counter (
        .clk(clk), .rst(rst), .eof_valid(eof_valid),
        .err_align(err_align), .err_crc(err_crc), .err_fifo_ovf(err_fifo_ovf),
        .err_rx_off(err_rx_off), .addr_reject(addr_reject),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {16'h0, m_cnt};
            2'd1:    return {31'h0, m_sticky};
            2'd2:    return {31'h0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic counts(input logic e, input logic [4:0] f);
        return e & (|f[4:1]) & ~f[0];
    endfunction

    // flags = {align, crc, fifo_ovf, rx_off, reject}
    task automatic step(input logic e, input logic [4:0] f, input logic rd, input logic wr,
                        input logic [1:0] a, input logic [31:0] wd, input string tag);
        logic set;
        @(negedge clk);
        eof_valid = e;
        {err_align, err_crc, err_fifo_ovf, err_rx_off, addr_reject} = f;
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        if (rd) chk(reg_rdata, model_read(a), tag);
        set = 1'b0;
        if (rd && a == 2'd0)      m_cnt = 16'h0;
        else if (wr && a == 2'd0) m_cnt = wd[15:0];
        else if (counts(e, f)) begin
            if (m_cnt == 16'hFFFF) set = 1'b1;
            m_cnt = m_cnt + 16'd1;
        end
        if (set) m_sticky = 1'b1;
        else if (wr && a == 2'd1 && wd[0]) m_sticky = 1'b0;
        if (wr && a == 2'd2) m_en = wd[0];
        m_irq = m_sticky & m_en;
        @(posedge clk);
        #1;
        chk({31'h0, irq}, {31'h0, m_irq}, "R11 irq");
    endtask

    task automatic rd_tally(input string tag);
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd0, 32'h0, tag);
    endtask
    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        step(1'b0, 5'b0, 1'b0, 1'b1, a, v, "write");
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        m_cnt = 16'h7FFF; m_sticky = 1'b0; m_en = 1'b0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 chk({31'h0, irq}, 32'h0, "R1 irq after reset");
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd1, 32'h0, "R1 status reset");
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd2, 32'h0, "R1 enable reset");
        rd_tally("R1 tally reset 7FFF / R2 read");
        rd_tally("R2 cleared by read");

        wr_reg(2'd0, 32'hABCD_1234);
        rd_tally("R3 preload");
        wr_reg(2'd0, 32'h0000_0010);
        step(1'b1, 5'b10000, 0, 0, 2'd0, 0, "R4 align");
        step(1'b1, 5'b01000, 0, 0, 2'd0, 0, "R4 crc");
        rd_tally("R4 count 0x12");
        step(1'b1, 5'b00100, 0, 0, 2'd0, 0, "R5 fifo");
        step(1'b1, 5'b00010, 0, 0, 2'd0, 0, "R5 rx off");
        rd_tally("R5 count 2");
        step(1'b1, 5'b00001, 0, 0, 2'd0, 0, "R6 reject");
        step(1'b1, 5'b01001, 0, 0, 2'd0, 0, "R6 reject with crc");
        step(1'b1, 5'b00000, 0, 0, 2'd0, 0, "R6 clean frame");
        step(1'b0, 5'b11110, 0, 0, 2'd0, 0, "R6 flags no strobe");
        rd_tally("R6 count 0");
        step(1'b1, 5'b11110, 0, 0, 2'd0, 0, "R7 all flags");
        rd_tally("R7 count 1");

        wr_reg(2'd0, 32'h0000_FFFF);
        step(1'b1, 5'b01000, 0, 0, 2'd0, 0, "R8 wrap");
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd1, 0, "R8 sticky set");
        rd_tally("R8 count 0");
        wr_reg(2'd2, 32'h1);
        wr_reg(2'd1, 32'h0);
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd1, 0, "R10 write 0 keeps flag");
        wr_reg(2'd1, 32'h1);
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd1, 0, "R10 w1c clears");

        wr_reg(2'd0, 32'h0000_FFFF);
        step(1'b1, 5'b10000, 1'b1, 1'b0, 2'd0, 0, "R9 read beats inc");
        rd_tally("R9 zero after read");
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd1, 0, "R9 no flag");
        wr_reg(2'd0, 32'h0000_FFFF);
        step(1'b1, 5'b00100, 1'b0, 1'b1, 2'd0, 32'h0000_0005, "R9 write beats inc");
        rd_tally("R9 preload kept");

        wr_reg(2'd0, 32'h0000_FFFF);
        step(1'b1, 5'b01000, 1'b0, 1'b1, 2'd1, 32'h1, "R10 wrap with clear");
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd1, 0, "R10 set wins");
        wr_reg(2'd2, 32'h0);
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd3, 0, "R11 addr3 zero");
        wr_reg(2'd2, 32'h1);
        step(1'b0, 5'b0, 1'b1, 1'b0, 2'd2, 0, "R11 enable readback");

        for (int i = 0; i < 4000; i++) begin
            logic        e, rd, wr;
            logic [4:0]  f;
            logic [1:0]  a;
            logic [31:0] wd;
            e  = ($urandom_range(0, 1) == 1);
            f  = {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 5) == 0)};
            rd = ($urandom_range(0, 19) == 0);
            wr = !rd && ($urandom_range(0, 24) == 0);
            a  = 2'($urandom_range(0, 3));
            wd = $urandom();
            if ($urandom_range(0, 1) == 1) wd[15:0] = 16'hFFF0 | 16'($urandom_range(0, 15));
            step(e, f, rd, wr, a, wd, "R2/R8/R10 random read");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule